// File: doc/BRIEF.md
# Vertical Line Decimate/Replicate Scaler

This block scales an image in the sub-scan (vertical) direction by deciding, per incoming line, how many output lines that line produces: none (the line is dropped), one, or several (the line is replayed). It does not interpolate and does not hold pixel data. A separate line buffer stores the line, and this block steers it. Each output line gets a strobe, with a flag that marks the strobe as a replay of the stored line. A final advance strobe tells the buffer to move on to the next input line.

Each line start arrives on a valid/ready handshake. In fractional mode, an 18-bit factor is added to a phase accumulator for each accepted line. The factor has 2 integer bits and 16 fraction bits, so the step is 1/65536 and the factor is capped at 2.0. The carry out of the fraction becomes the line's repeat count, and the remaining fraction is kept for the next line. In integer mode, every line is repeated a programmed count of 2 to 65535 times. A 16-bit down-counter paces these repeats. A page-start pulse clears the phase, so every page scales the same way.

The sequencer has three states. In IDLE, `in_ready` is high. IDLE goes to EMIT when a line is accepted with a non-zero count, and goes straight to ADVANCE when the count is zero. EMIT produces one strobe per cycle and moves to ADVANCE when the last repeat is output. ADVANCE asserts `advance` for one cycle and always returns to IDLE.

Top module: `vline_scaler`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_strobe`, `out_replay`, `advance` and `count_vld` are 0.
- R2: In fractional mode (`mode_int`=0), the count equals bits [17:16] of (phase + factor), and phase takes bits [15:0] of that sum. The factor carries 16 fraction bits, so 0x10000 is 1.0.
- R3: A fractional factor above 0x20000 is treated as 0x20000, so a fractional count never exceeds 2.
- R4: When the count is 0, `advance` pulses in the cycle after acceptance, and no `out_strobe` occurs for that line.
- R5: When the count N is at least 1, `out_strobe` is high for N consecutive cycles, starting the cycle after acceptance. `out_replay` is 0 on the first of these strobes and 1 on the rest. `advance` pulses in the cycle right after the last strobe.
- R6: In integer mode (`mode_int`=1), an `int_factor` from 2 to 65535 gives a count equal to `int_factor`.
- R7: In integer mode, an `int_factor` of 0 or 1 gives a count of 1.
- R8: `in_ready` is 0 from the cycle after acceptance through the advance cycle, and returns to 1 in the cycle after `advance`.
- R9: A `page_start` pulse sets the phase to zero. When `page_start` coincides with an acceptance, that line uses a zero phase.
- R10: `count_vld` pulses in the cycle after acceptance, and `line_count` then shows the count for that line.
- R11: A line accepted in integer mode leaves the fractional phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Clears the scaling phase |
| mode_int | input | 1 | 0 = fractional factor, 1 = integer factor |
| frac_factor | input | 18 | Fractional factor, 2.16 fixed point |
| int_factor | input | 16 | Integer repeat count |
| in_valid | input | 1 | Line start offered |
| in_ready | output | 1 | Ready to accept a line start |
| line_count | output | 16 | Repeat count of the last accepted line |
| count_vld | output | 1 | One-cycle pulse: `line_count` is new |
| out_strobe | output | 1 | One pulse per output line |
| out_replay | output | 1 | Current strobe replays the stored line |
| advance | output | 1 | Line buffer may move to the next line |

## Verification
The assertions check the following on every cycle:
- The handshake is blocked while a line is in progress.
- `advance` is a single pulse that never overlaps a strobe and follows the last strobe.
- The number of strobes equals the reported count.
- The first strobe is never flagged as a replay.
- Fractional counts stay at or below 2, and integer counts are never 0.

Some behaviour needs a known history, and only the bench scenarios can show it: the exact count values that the phase accumulation produces across a sequence of lines, the clearing of the phase by a page start, the preservation of the phase across integer-mode lines, and the full 65535-fold replication.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_EMIT    = 2'd1,
        ST_ADVANCE = 2'd2
    } vsc_state_e;

endpackage

// File: rtl/vsc_ratio.sv
module vsc_ratio #(
    parameter int FRAC_W = 16,
    parameter int INT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start,
    input  logic              take,
    input  logic              mode_int,
    input  logic [FRAC_W+1:0] frac_factor,
    input  logic [INT_W-1:0]  int_factor,
    output logic [INT_W-1:0]  count
);

    localparam int FW = FRAC_W + 2;
    localparam logic [FW-1:0] FACTOR_MAX = {2'b10, {FRAC_W{1'b0}}};

    logic [FRAC_W-1:0] phase_q;
    logic [FRAC_W-1:0] phase_base;
    logic [FW-1:0]     factor_c;
    logic [FW-1:0]     sum;
    logic [1:0]        frac_cnt;
    logic [INT_W-1:0]  int_cnt;

    // Cap the factor at 2.0 so one line is never output more than twice.
    always_comb begin
        factor_c = (frac_factor > FACTOR_MAX) ? FACTOR_MAX : frac_factor;
    end

    always_comb begin
        phase_base = page_start ? '0 : phase_q;
        sum        = {2'b00, phase_base} + factor_c;
        frac_cnt   = sum[FW-1:FRAC_W];
    end

    // Factors 0 and 1 collapse to a single pass-through output.
    always_comb begin
        if (int_factor < INT_W'(2)) begin
            int_cnt = INT_W'(1);
        end else begin
            int_cnt = int_factor;
        end
        count = mode_int ? int_cnt : INT_W'(frac_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (take && !mode_int) begin
            phase_q <= sum[FRAC_W-1:0];
        end else if (page_start) begin
            phase_q <= '0;
        end
    end

endmodule

// File: rtl/vsc_seq.sv
module vsc_seq
    import vsc_pkg::*;
#(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [INT_W-1:0] count,
    output logic             take,
    output logic             in_ready,
    output logic [INT_W-1:0] line_count,
    output logic             count_vld,
    output logic             out_strobe,
    output logic             out_replay,
    output logic             advance
);

    vsc_state_e       state_q, state_d;
    logic [INT_W-1:0] remain_q;
    logic             first_q;

    assign take = in_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = (count == '0) ? ST_ADVANCE : ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (remain_q == INT_W'(1)) begin
                    state_d = ST_ADVANCE;
                end
            end
            ST_ADVANCE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Down-counter of remaining output lines and first-strobe marker.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q   <= '0;
            first_q    <= 1'b0;
            line_count <= '0;
            count_vld  <= 1'b0;
        end else begin
            count_vld <= take;
            if (take) begin
                remain_q   <= count;
                first_q    <= 1'b1;
                line_count <= count;
            end else if (state_q == ST_EMIT) begin
                remain_q <= remain_q - INT_W'(1);
                first_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        in_ready   = 1'b0;
        out_strobe = 1'b0;
        out_replay = 1'b0;
        advance    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_EMIT: begin
                out_strobe = 1'b1;
                out_replay = !first_q;
            end
            ST_ADVANCE: begin
                advance = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vline_scaler.sv
module vline_scaler #(
    parameter int FRAC_W = 16,
    parameter int INT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start,
    input  logic              mode_int,
    input  logic [FRAC_W+1:0] frac_factor,
    input  logic [INT_W-1:0]  int_factor,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [INT_W-1:0]  line_count,
    output logic              count_vld,
    output logic              out_strobe,
    output logic              out_replay,
    output logic              advance
);

    logic             take;
    logic [INT_W-1:0] count;

    vsc_ratio #(
        .FRAC_W (FRAC_W),
        .INT_W  (INT_W)
    ) u_ratio (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_start  (page_start),
        .take        (take),
        .mode_int    (mode_int),
        .frac_factor (frac_factor),
        .int_factor  (int_factor),
        .count       (count)
    );

    vsc_seq #(
        .INT_W (INT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .count      (count),
        .take       (take),
        .in_ready   (in_ready),
        .line_count (line_count),
        .count_vld  (count_vld),
        .out_strobe (out_strobe),
        .out_replay (out_replay),
        .advance    (advance)
    );

endmodule

// File: rtl/vline_scaler_chk.sv
module vline_scaler_chk #(
    parameter int INT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_int,
    input logic             in_ready,
    input logic [INT_W-1:0] line_count,
    input logic             count_vld,
    input logic             out_strobe,
    input logic             out_replay,
    input logic             advance
);

    logic [INT_W-1:0] seen_q;
    logic [INT_W-1:0] expect_q;
    logic             mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= '0;
            expect_q <= '0;
            mode_q   <= 1'b0;
        end else begin
            mode_q <= mode_int;
            if (count_vld) begin
                seen_q   <= out_strobe ? INT_W'(1) : '0;
                expect_q <= line_count;
            end else if (out_strobe) begin
                seen_q <= seen_q + INT_W'(1);
            end
        end
    end

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe || advance) |-> !in_ready);

    a_r8_ready_after_advance: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> in_ready);

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> !advance);

    a_r5_advance_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_strobe) |-> advance);

    a_r5_first_not_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && count_vld) |-> !out_replay);

    a_r5_strobe_total: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !count_vld) |-> (seen_q == expect_q));

    a_r4_zero_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count_vld && line_count == '0) |-> (advance && !out_strobe));

    a_r3_frac_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (count_vld && !mode_q) |-> (line_count <= INT_W'(2)));

    a_r7_int_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (count_vld && mode_q) |-> (line_count != '0));

endmodule

bind vline_scaler vline_scaler_chk #(.INT_W(INT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_int   (mode_int),
    .in_ready   (in_ready),
    .line_count (line_count),
    .count_vld  (count_vld),
    .out_strobe (out_strobe),
    .out_replay (out_replay),
    .advance    (advance)
);

// File: tb/tb_vline_scaler.sv
module tb_vline_scaler;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic        mode;
        logic [17:0] frac;
        logic [15:0] intf;
        logic [15:0] expc;
    } vec_t;

    // Sequence after a page start; phase values worked out by hand (R2, R3, R6, R7, R11).
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 18'h10000, 16'd0, 16'd1},  // 1.0 -> 1, phase 0
        '{1'b0, 18'h08000, 16'd0, 16'd0},  // 0.5 -> 0, phase 8000
        '{1'b0, 18'h08000, 16'd0, 16'd1},  // -> 1, phase 0
        '{1'b0, 18'h18000, 16'd0, 16'd1},  // 1.5 -> 1, phase 8000
        '{1'b0, 18'h18000, 16'd0, 16'd2},  // -> 2, phase 0
        '{1'b0, 18'h20000, 16'd0, 16'd2},  // 2.0 -> 2
        '{1'b0, 18'h3FFFF, 16'd0, 16'd2},  // capped R3
        '{1'b0, 18'h0C000, 16'd0, 16'd0},  // -> 0, phase C000
        '{1'b1, 18'h00000, 16'd3, 16'd3},  // integer R6
        '{1'b1, 18'h00000, 16'd0, 16'd1},  // R7
        '{1'b1, 18'h00000, 16'd1, 16'd1},  // R7
        '{1'b0, 18'h04000, 16'd0, 16'd1},  // phase C000 kept, R11
        '{1'b1, 18'h00000, 16'd2, 16'd2},  // R6
        '{1'b0, 18'h0FFFF, 16'd0, 16'd0}   // phase FFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic        mode_int = 1'b0;
    logic [17:0] frac_factor = '0;
    logic [15:0] int_factor = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] line_count;
    logic        count_vld;
    logic        out_strobe;
    logic        out_replay;
    logic        advance;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vline_scaler dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_start  (page_start),
        .mode_int    (mode_int),
        .frac_factor (frac_factor),
        .int_factor  (int_factor),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .line_count  (line_count),
        .count_vld   (count_vld),
        .out_strobe  (out_strobe),
        .out_replay  (out_replay),
        .advance     (advance)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_line(input logic m, input logic [17:0] f, input logic [15:0] ni,
                             input int expc, input string req);
        int n = 0;
        int idx = 0;
        int adv_at = -1;
        int bad_replay = 0;
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "ready before line", int'(in_ready), 1);
        mode_int    = m;
        frac_factor = f;
        int_factor  = ni;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(count_vld == 1'b1, "R10", "count valid pulse", int'(count_vld), 1);
        check(int'(line_count) == expc, req, "repeat count", int'(line_count), expc);
        check(in_ready == 1'b0, "R8", "busy after accept", int'(in_ready), 0);
        while (adv_at < 0 && idx < 70000) begin
            if (out_strobe) begin
                if (out_replay != (n != 0)) bad_replay++;
                n++;
            end
            if (advance) begin
                adv_at = idx;
            end else begin
                @(negedge clk);
                idx++;
            end
        end
        check(bad_replay == 0, "R5", "replay flag errors", bad_replay, 0);
        check(n == expc, expc == 0 ? "R4" : "R5", "strobe total", n, expc);
        check(adv_at == expc, expc == 0 ? "R4" : "R5", "advance cycle", adv_at, expc);
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "ready after advance", int'(in_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        check(out_strobe == 1'b0, "R1", "out_strobe in reset", int'(out_strobe), 0);
        check(advance == 1'b0, "R1", "advance in reset", int'(advance), 0);
        check(count_vld == 1'b0, "R1", "count_vld in reset", int'(count_vld), 0);
        check(out_replay == 1'b0, "R1", "out_replay in reset", int'(out_replay), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && !out_strobe && !advance, "R1", "state after reset",
              int'({in_ready, out_strobe, advance}), 4);

        page_start = 1'b1;
        @(negedge clk);
        page_start = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            send_line(VECS[i].mode, VECS[i].frac, VECS[i].intf, int'(VECS[i].expc),
                      VECS[i].mode ? "R6" : "R2");
        end

        // R9: phase is FFFF now; after a page start a tiny factor must drop the line.
        @(negedge clk);
        page_start = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
        send_line(1'b0, 18'h00001, 16'd0, 0, "R9");
        // Phase is 1; page start on the same cycle as acceptance uses zero phase (R9).
        @(negedge clk);
        page_start  = 1'b1;
        mode_int    = 1'b0;
        frac_factor = 18'h0FFFF;
        in_valid    = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
        in_valid   = 1'b0;
        check(int'(line_count) == 0, "R9", "concurrent page start", int'(line_count), 0);
        repeat (3) @(negedge clk);

        // R6 upper bound of the integer factor
        send_line(1'b1, 18'h00000, 16'd65535, 65535, "R6");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule